// File: doc/BRIEF.md
# DMA Request Capture and Synchronizer

This block collects transfer requests for a DMA controller. It serves a fixed number of request sources and four request classes: burst, single, last burst and last single. A request in any class can come from a dedicated peripheral input vector or from a software request register. A small read/write register port reaches that register. For each class, the block gives the channel arbiter one pending-request vector. Each bit of that vector is the OR of the peripheral line and the software bit for the same source.

A software request bit is held until a per-source completion pulse arrives, and the pulse clears it. Each class passes its peripheral inputs through a two-flop synchronizer. A control register can bypass that synchronizer for each class, and this register resets to all-synchronized. A global enable input forces every output vector to zero but keeps the captured software requests.

The register map uses word addresses on `reg_addr_i`:
- Addresses 0 to 3 hold the software requests for burst, single, last burst and last single, in that order.
- Address 4 holds the bypass control in bits [3:0], in the same class order.

Top module: `dma_req_capture`

## Requirements
- R1: A write of 1 to a bit of a software request register (addresses 0 to 3) sets that source's request in that class on the next clock edge. A written 0 leaves the bit unchanged.
- R2: A set software bit stays set until a pulse on the matching bit of `done_i`, which clears it in every class. A pulse on other bits leaves it set.
- R3: A software write of 1 and a `done_i` pulse on the same bit in the same cycle leave the bit set.
- R4: A read of addresses 0 to 3 on `reg_rdata_o` returns the pending software bits of that class, zero-extended. A read of address 4 returns the bypass control in bits [3:0]. The read path is combinational.
- R5: While enabled, each output vector is the bitwise OR of the class's peripheral path and its software register. Classes do not affect one another.
- R6: When a class's bypass bit is 0, a change on its peripheral input reaches the output after exactly two rising clock edges.
- R7: When a class's bypass bit is 1, its peripheral input reaches the output in the same cycle. Bypass is chosen for each class separately.
- R8: While `en_i` is 0, all four output vectors are zero. Software writes are still captured, and the captured bits appear once `en_i` returns to 1.
- R9: After reset, all software bits, synchronizer stages and bypass bits are 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global request enable |
| per_burst_i | input | 16 | Peripheral burst requests |
| per_single_i | input | 16 | Peripheral single requests |
| per_lburst_i | input | 16 | Peripheral last-burst requests |
| per_lsingle_i | input | 16 | Peripheral last-single requests |
| done_i | input | 16 | Per-source completion pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| req_burst_o | output | 16 | Pending burst requests |
| req_single_o | output | 16 | Pending single requests |
| req_lburst_o | output | 16 | Pending last-burst requests |
| req_lsingle_o | output | 16 | Pending last-single requests |

## Verification
The assertions check the following on every cycle:
- A write never loses to a completion pulse.
- Completion clears exactly the bits it names.
- No software bit rises without a write.
- The synchronized path lags its input by two edges.
- Bypass bits and captured requests stay put while untouched.
- Enabled outputs always cover the software bits.

Only the bench scenarios can show the following:
- The exact address-to-class mapping and the readback values.
- Isolation between classes.
- The bypass taking effect in the same cycle for a mixed bypass pattern.
- Requests written while disabled appearing again after re-enable.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned NUM_CLS = 4;
  localparam int unsigned CLS_W   = $clog2(NUM_CLS);

  typedef enum logic [CLS_W-1:0] {
    CLS_BURST   = 2'd0,
    CLS_SINGLE  = 2'd1,
    CLS_LBURST  = 2'd2,
    CLS_LSINGLE = 2'd3
  } req_cls_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = bypass_i ? d_i : sync_q;

  // edges seen since reset, saturating at 2
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && !bypass_i) |-> (q_o == $past(d_i, 2))); // R6
endmodule

// File: rtl/dma_soft_req.sv
module dma_soft_req #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pend_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign q_o = pend_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i))); // R3

  AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((q_o & $past(clr_i & ~set_i)) == '0)); // R2

  AST_NO_SPUR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q_o & ~$past(q_o) & ~$past(set_i)) == '0)); // R1
endmodule

// File: rtl/dma_req_regif.sv
module dma_req_regif #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned NUM_CLS = 4,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic [NUM_CLS-1:0][NUM_SRC-1:0]   soft_i,
  output logic [NUM_CLS-1:0][NUM_SRC-1:0]   set_o,
  output logic [NUM_CLS-1:0]                bypass_o,
  output logic [DATA_W-1:0]                 rdata_o
);
  localparam logic [ADDR_W-1:0] SYNC_ADR = ADDR_W'(NUM_CLS);

  logic [NUM_CLS-1:0] bypass_q;
  logic               sync_we;

  assign sync_we = we_i && (addr_i == SYNC_ADR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bypass_q <= '0;
    else if (sync_we) bypass_q <= wdata_i[NUM_CLS-1:0];
  end

  assign bypass_o = bypass_q;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_set
    assign set_o[c] = (we_i && addr_i == ADDR_W'(c)) ? wdata_i[NUM_SRC-1:0] : '0;
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (addr_i == ADDR_W'(c)) rdata_o[NUM_SRC-1:0] = soft_i[c];
    end
    if (addr_i == SYNC_ADR) rdata_o[NUM_CLS-1:0] = bypass_q;
  end

  AST_BYPASS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_we |=> $stable(bypass_o)); // R7
endmodule

// File: rtl/dma_req_capture.sv
module dma_req_capture
  import dma_req_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [NUM_SRC-1:0] per_burst_i,
  input  logic [NUM_SRC-1:0] per_single_i,
  input  logic [NUM_SRC-1:0] per_lburst_i,
  input  logic [NUM_SRC-1:0] per_lsingle_i,
  input  logic [NUM_SRC-1:0] done_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic [NUM_SRC-1:0] req_burst_o,
  output logic [NUM_SRC-1:0] req_single_o,
  output logic [NUM_SRC-1:0] req_lburst_o,
  output logic [NUM_SRC-1:0] req_lsingle_o
);
  logic [NUM_CLS-1:0][NUM_SRC-1:0] per_raw, per_path, soft_q, soft_set, req_all;
  logic [NUM_CLS-1:0]              bypass;

  assign per_raw[CLS_BURST]   = per_burst_i;
  assign per_raw[CLS_SINGLE]  = per_single_i;
  assign per_raw[CLS_LBURST]  = per_lburst_i;
  assign per_raw[CLS_LSINGLE] = per_lsingle_i;

  dma_req_regif #(
    .NUM_SRC(NUM_SRC), .NUM_CLS(NUM_CLS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .soft_i  (soft_q),
    .set_o   (soft_set),
    .bypass_o(bypass),
    .rdata_o (reg_rdata_o)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    dma_req_sync #(.WIDTH(NUM_SRC)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .bypass_i(bypass[c]),
      .d_i     (per_raw[c]),
      .q_o     (per_path[c])
    );

    dma_soft_req #(.WIDTH(NUM_SRC)) u_soft (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (soft_set[c]),
      .clr_i (done_i),
      .q_o   (soft_q[c])
    );

    assign req_all[c] = en_i ? (per_path[c] | soft_q[c]) : '0;

    AST_SOFT_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |-> ((req_all[c] & soft_q[c]) == soft_q[c])); // R5
  end

  assign req_burst_o   = req_all[CLS_BURST];
  assign req_single_o  = req_all[CLS_SINGLE];
  assign req_lburst_o  = req_all[CLS_LBURST];
  assign req_lsingle_o = req_all[CLS_LSINGLE];

  AST_HOLD_WHILE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !reg_we_i && done_i == '0) |=> $stable(soft_q)); // R8
endmodule

// File: tb/dma_req_capture_tb.sv
`timescale 1ns/1ps
module dma_req_capture_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic [3:0][15:0] per = '0;
  logic [15:0] done_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [3:0][15:0] req;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dma_req_capture u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .per_burst_i(per[0]), .per_single_i(per[1]),
    .per_lburst_i(per[2]), .per_lsingle_i(per[3]),
    .done_i(done_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .req_burst_o(req[0]), .req_single_o(req[1]),
    .req_lburst_o(req[2]), .req_lsingle_o(req[3])
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // write at negedge, returns just after the capturing edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [15:0] dn);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; done_i = dn;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0; done_i = '0;
  endtask

  task automatic pulse_done(input logic [15:0] dn);
    @(negedge clk_i);
    done_i = dn;
    @(posedge clk_i); #1;
    done_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a; #0.5;
    d = reg_rdata_o;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic [15:0] p;
    repeat (3) @(posedge clk_i);
    #1;
    // R9 reset state
    for (int c = 0; c < 4; c++) chk("R9 reset req", 32'(req[c]), 32'h0);
    for (int a = 0; a < 5; a++) begin rd(3'(a), rv); chk("R9 reset reg", rv, 32'h0); end
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    for (int c = 0; c < 4; c++) chk("R9 after release", 32'(req[c]), 32'h0);

    // R1 R2 R4 R5 sweep over every class and bit
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 16; i++) begin
        logic [15:0] b;
        b = 16'h1 << i;
        wr(3'(c), 32'(b), 16'h0);
        chk("R1 set", 32'(req[c]), 32'(b));
        for (int o = 0; o < 4; o++)
          if (o != c) chk("R5 class isolation", 32'(req[o]), 32'h0);
        rd(3'(c), rv); chk("R4 readback", rv, 32'(b));
        wr(3'(c), 32'h0, 16'h0);
        chk("R1 write zero ignored", 32'(req[c]), 32'(b));
        pulse_done(~b);
        chk("R2 other done keeps", 32'(req[c]), 32'(b));
        pulse_done(b);
        chk("R2 done clears", 32'(req[c]), 32'h0);
        rd(3'(c), rv); chk("R2 readback cleared", rv, 32'h0);
      end
    end

    // R2: one done clears the same source in every class
    for (int c = 0; c < 4; c++) wr(3'(c), 32'h0000_8001, 16'h0);
    pulse_done(16'h0001);
    for (int c = 0; c < 4; c++) chk("R2 done all classes", 32'(req[c]), 32'h8000);
    pulse_done(16'hFFFF);

    // R3 collision: write wins
    wr(3'd1, 32'h0000_00F0, 16'h0030);
    chk("R3 set with done", 32'(req[1]), 32'h00F0);
    wr(3'd2, 32'h0000_000F, 16'h0);
    wr(3'd2, 32'h0000_0003, 16'h000F);
    chk("R3 partial collision", 32'(req[2]), 32'h0003);
    pulse_done(16'hFFFF);
    for (int c = 0; c < 4; c++) chk("R3 cleanup", 32'(req[c]), 32'h0);

    // R6 synchronized peripheral path, two-edge latency
    p = 16'hA5C3;
    for (int c = 0; c < 4; c++) begin
      p = p * 16'd109 + 16'd7;
      @(negedge clk_i); per[c] = p;
      @(posedge clk_i); #1;
      chk("R6 after one edge", 32'(req[c]), 32'h0);
      @(posedge clk_i); #1;
      chk("R6 after two edges", 32'(req[c]), 32'(p));
      @(negedge clk_i); per[c] = '0;
      @(posedge clk_i); #1;
      chk("R6 fall one edge", 32'(req[c]), 32'(p));
      @(posedge clk_i); #1;
      chk("R6 fall two edges", 32'(req[c]), 32'h0);
    end

    // R7 mixed bypass: classes 0,2 bypassed
    wr(3'd4, 32'h5, 16'h0);
    rd(3'd4, rv); chk("R4 sync readback", rv, 32'h5);
    @(negedge clk_i);
    per = {16'h3C3C, 16'h1111, 16'h2222, 16'h4444};
    #1;
    chk("R7 bypass class0", 32'(req[0]), 32'h4444);
    chk("R7 bypass class2", 32'(req[2]), 32'h1111);
    chk("R7 synced class1", 32'(req[1]), 32'h0);
    chk("R7 synced class3", 32'(req[3]), 32'h0);
    @(posedge clk_i); @(posedge clk_i); #1;
    chk("R7 synced class3 later", 32'(req[3]), 32'h3C3C);

    // R5 OR of soft and peripheral
    wr(3'd0, 32'h0000_00FF, 16'h0);
    chk("R5 or merge", 32'(req[0]), 32'h44FF);
    @(negedge clk_i); per[0] = 16'hF000; #1;
    chk("R5 or merge new", 32'(req[0]), 32'hF0FF);

    // R8 enable gating
    @(negedge clk_i); en_i = 1'b0; #1;
    for (int c = 0; c < 4; c++) chk("R8 gated", 32'(req[c]), 32'h0);
    wr(3'd3, 32'h0000_1234, 16'h0);
    chk("R8 gated after write", 32'(req[3]), 32'h0);
    rd(3'd3, rv); chk("R8 held while off", rv, 32'h1234);
    @(negedge clk_i); en_i = 1'b1; #1;
    chk("R8 restored", 32'(req[3]), 32'h3C3C | 32'h1234);
    chk("R8 restored class0", 32'(req[0]), 32'hF0FF);

    rd(3'd7, rv); chk("R4 unmapped read", rv, 32'h0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule